// File: doc/BRIEF.md
# Boot-remap address decoder

This block decodes a 32-bit processor address into chip selects for a boot ROM, DRAM, a dual UART, a CompactFlash interface and a one-location remap register. Coming out of reset, the ROM answers for every address below 0xFF00_0000. This lets the processor fetch its reset vectors from address zero, whatever value they hold. The top 16 MB form I/O space.

A single sticky flag changes the map. Any read or write of the trigger address 0xFFFF_8000 sets it. From then on, the low 128 MB decode to DRAM and the ROM moves up to a 16 MB window at 0xFE00_0000. The I/O selects stay where they were. The flag changes at the clock edge that ends the triggering access, so that access is still decoded under the boot map.

Alongside the selects, the block gives the ROM offset and a DRAM row/column split of the address. The DRAM address is masked to the installed size, so a smaller part repeats through the DRAM window. Any strobed address that hits no region raises a bus-error output instead of a select.

Top module: `boot_remap_decoder`

## Requirements
- R1: Reset clears the remap flag. While reset is held and after it is released, a strobed address 0x0000_0000 selects the ROM.
- R2: With the flag clear, every strobed address from 0x0000_0000 to 0xFEFF_FFFF asserts `sel_rom_o`. `rom_addr_o` equals address bits [18:0], so the 512 KB ROM repeats through the window.
- R3: In both maps, a strobed access asserts:
  - `sel_uart_o` for 0xFFFF_F000..0xFFFF_FFFF;
  - `sel_cf_o` for 0xFFFF_E000..0xFFFF_EFFF;
  - `sel_remap_o` for 0xFFFF_8000..0xFFFF_8FFF.
- R4: A strobed read (`rw_i`=1) or write (`rw_i`=0) at exactly 0xFFFF_8000 sets the flag at the clock edge that ends that cycle. The triggering access itself is decoded with the flag clear.
- R5: Strobed accesses to other addresses inside 0xFFFF_8000..0xFFFF_8FFF assert `sel_remap_o` but leave the flag unchanged.
- R6: The flag is sticky. Further trigger accesses and any other traffic leave it set, and only reset clears it.
- R7: With the flag set, 0x0000_0000..0x07FF_FFFF selects DRAM and 0xFE00_0000..0xFEFF_FFFF selects the ROM with the same [18:0] offset. Other addresses below 0xFE00_0000 no longer select the ROM.
- R8: A strobed address that matches no region in the current map asserts `bus_err_o` and no select. With the flag clear this applies to 0xFF00_0000..0xFFFF_7FFF and 0xFFFF_9000..0xFFFF_DFFF. With the flag set it also applies to 0x0800_0000..0xFDFF_FFFF.
- R9: With `as_i` low, all selects and `bus_err_o` are low, and no address changes the flag.
- R10: The size code `dram_size_i` gives the number of address bits kept:
  - 2'b00: 16 MB, bits [23:0];
  - 2'b01: 64 MB, bits [25:0];
  - 2'b10: 128 MB, bits [26:0];
  - 2'b11: reserved, treated as 16 MB.

  Bits above the kept ones are zeroed. Of the masked address, `dram_col_o` = bits [13:2] and `dram_row_o` = bits [26:14].
- R11: At most one of the six outputs `sel_rom_o`, `sel_dram_o`, `sel_uart_o`, `sel_cf_o`, `sel_remap_o`, `bus_err_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low reset, clears the remap flag |
| addr_i | input | 32 | Byte address from the processor |
| as_i | input | 1 | Address strobe: address valid this cycle |
| rw_i | input | 1 | 1 = read, 0 = write |
| dram_size_i | input | 2 | Installed DRAM size code (see R10) |
| sel_rom_o | output | 1 | Boot ROM select |
| sel_dram_o | output | 1 | DRAM select |
| sel_uart_o | output | 1 | Dual UART select |
| sel_cf_o | output | 1 | CompactFlash select |
| sel_remap_o | output | 1 | Remap register select |
| bus_err_o | output | 1 | Strobed access to an unmapped address |
| rom_addr_o | output | 19 | ROM byte offset |
| dram_row_o | output | 13 | DRAM row address after size masking |
| dram_col_o | output | 12 | DRAM column address after size masking |

## Verification
The assertions assume three things about the inputs:
- the address and strobe settle well before each rising edge and are held across it;
- the size code does not change while DRAM is in use;
- reset is driven synchronously to the clock.

The bench therefore changes `addr_i`, `as_i`, `rw_i` and `dram_size_i` only on falling edges and samples the outputs one nanosecond later. Reset is asserted and released on falling edges as well. Because the strobe is always driven, even idle cycles present a defined address. The size code changes only between accesses in the aliasing scenario.

// File: rtl/brd_pkg.sv
`timescale 1ns/1ps
package brd_pkg;
    localparam int ADDR_W   = 32;
    localparam int ROM_AW   = 19;
    localparam int DRAM_AW  = 27;
    localparam int BYTE_LSB = 2;
    localparam int COL_W    = 12;
    localparam int ROW_W    = DRAM_AW - BYTE_LSB - COL_W;

    localparam logic [ADDR_W-1:0] REMAP_TRIG = 32'hFFFF_8000;

    typedef enum logic [1:0] {
        DRAM_16M  = 2'b00,
        DRAM_64M  = 2'b01,
        DRAM_128M = 2'b10,
        DRAM_RSVD = 2'b11
    } dram_size_e;

    typedef struct packed {
        logic remapped;
    } remap_st_t;

    typedef struct packed {
        logic err;
        logic remap;
        logic cf;
        logic uart;
        logic dram;
        logic rom;
    } sel_t;
endpackage

// File: rtl/brd_remap_state.sv
`timescale 1ns/1ps
module brd_remap_state
    import brd_pkg::*;
#(
    parameter int               AW   = ADDR_W,
    parameter logic [AW-1:0]    TRIG = REMAP_TRIG
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          as_i,
    input  logic          rw_i,
    input  logic [AW-1:0] addr_i,
    output logic          remapped_o
);
    remap_st_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit  = as_i && (addr_i == TRIG);
        st_d = st_q;
        if (hit) begin
            st_d.remapped = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remapped_o = st_q.remapped;

    // R4: a read of the trigger sets the flag
    a_r4_read_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_i && rw_i && addr_i == TRIG) |=> remapped_o);
    // R4: a write of the trigger sets the flag
    a_r4_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_i && !rw_i && addr_i == TRIG) |=> remapped_o);
    // R6: only reset clears the flag
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        remapped_o |=> remapped_o);
    // R5, R9: nothing but a strobed trigger access sets the flag
    a_r5_no_stray_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!remapped_o && !(as_i && addr_i == TRIG)) |=> !remapped_o);
endmodule

// File: rtl/brd_region_decode.sv
`timescale 1ns/1ps
module brd_region_decode
    import brd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic          as_i,
    input  logic          remapped_i,
    output sel_t          sel_o
);
    logic io_page;
    logic [3:0] page_nib;

    always_comb begin
        io_page  = (addr_i[AW-1:16] == '1);
        page_nib = addr_i[15:12];
        sel_o    = '0;
        if (!as_i) begin
            sel_o = '0;
        end else if (io_page && page_nib == 4'hF) begin
            sel_o.uart = 1'b1;
        end else if (io_page && page_nib == 4'hE) begin
            sel_o.cf = 1'b1;
        end else if (io_page && page_nib == 4'h8) begin
            sel_o.remap = 1'b1;
        end else if (!remapped_i && addr_i[AW-1:AW-8] != 8'hFF) begin
            sel_o.rom = 1'b1;
        end else if (remapped_i && addr_i[AW-1:DRAM_AW] == '0) begin
            sel_o.dram = 1'b1;
        end else if (remapped_i && addr_i[AW-1:AW-8] == 8'hFE) begin
            sel_o.rom = 1'b1;
        end else begin
            sel_o.err = 1'b1;
        end
    end
endmodule

// File: rtl/brd_dram_alias.sv
`timescale 1ns/1ps
module brd_dram_alias
    import brd_pkg::*;
#(
    parameter int DAW  = DRAM_AW,
    parameter int LSB  = BYTE_LSB,
    parameter int CW   = COL_W,
    parameter int RW   = DAW - LSB - CW
) (
    input  logic [DAW-1:0] addr_i,
    input  logic [1:0]     size_i,
    output logic [RW-1:0]  row_o,
    output logic [CW-1:0]  col_o
);
    localparam int W16  = 24;
    localparam int W64  = 26;
    localparam int W128 = DAW;

    int unsigned     keep_w;
    logic [DAW-1:0]  masked;

    always_comb begin
        unique case (dram_size_e'(size_i))
            DRAM_64M:  keep_w = W64;
            DRAM_128M: keep_w = W128;
            default:   keep_w = W16;
        endcase
    end

    for (genvar i = 0; i < DAW; i++) begin : g_mask
        assign masked[i] = addr_i[i] & (i < keep_w);
    end

    assign col_o = masked[LSB+CW-1:LSB];
    assign row_o = masked[DAW-1:LSB+CW];
endmodule

// File: rtl/boot_remap_decoder.sv
`timescale 1ns/1ps
module boot_remap_decoder
    import brd_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  as_i,
    input  logic                  rw_i,
    input  logic [1:0]            dram_size_i,
    output logic                  sel_rom_o,
    output logic                  sel_dram_o,
    output logic                  sel_uart_o,
    output logic                  sel_cf_o,
    output logic                  sel_remap_o,
    output logic                  bus_err_o,
    output logic [ROM_AW-1:0]     rom_addr_o,
    output logic [ROW_W-1:0]      dram_row_o,
    output logic [COL_W-1:0]      dram_col_o
);
    logic remapped;
    sel_t sel;

    brd_remap_state #(.AW(ADDR_W), .TRIG(REMAP_TRIG)) u_state (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .as_i       (as_i),
        .rw_i       (rw_i),
        .addr_i     (addr_i),
        .remapped_o (remapped)
    );

    brd_region_decode #(.AW(ADDR_W)) u_decode (
        .addr_i     (addr_i),
        .as_i       (as_i),
        .remapped_i (remapped),
        .sel_o      (sel)
    );

    brd_dram_alias #(.DAW(DRAM_AW), .LSB(BYTE_LSB), .CW(COL_W), .RW(ROW_W)) u_alias (
        .addr_i (addr_i[DRAM_AW-1:0]),
        .size_i (dram_size_i),
        .row_o  (dram_row_o),
        .col_o  (dram_col_o)
    );

    assign sel_rom_o   = sel.rom;
    assign sel_dram_o  = sel.dram;
    assign sel_uart_o  = sel.uart;
    assign sel_cf_o    = sel.cf;
    assign sel_remap_o = sel.remap;
    assign bus_err_o   = sel.err;
    assign rom_addr_o  = addr_i[ROM_AW-1:0];

    // R11: selects and bus error never overlap
    a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({sel_rom_o, sel_dram_o, sel_uart_o, sel_cf_o, sel_remap_o, bus_err_o}));
    // R9: no strobe, no select
    a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !as_i |-> !(sel_rom_o || sel_dram_o || sel_uart_o || sel_cf_o || sel_remap_o || bus_err_o));
    // R2: boot map puts ROM under everything below the I/O space
    a_r2_boot_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_i && !remapped && addr_i < 32'hFF00_0000) |-> sel_rom_o);
    // R7: remapped low memory is DRAM
    a_r7_low_dram: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_i && remapped && addr_i < 32'h0800_0000) |-> sel_dram_o);
    // R8: a strobed access lands somewhere or flags an error
    a_r8_err_or_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
        as_i |-> $onehot({sel_rom_o, sel_dram_o, sel_uart_o, sel_cf_o, sel_remap_o, bus_err_o}));
endmodule

// File: tb/boot_remap_decoder_bench.sv
`timescale 1ns/1ps
module boot_remap_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        as_s = 1'b0;
    logic        rw = 1'b1;
    logic [1:0]  size = 2'b10;
    logic        s_rom, s_dram, s_uart, s_cf, s_remap, s_err;
    logic [18:0] rom_a;
    logic [12:0] row;
    logic [11:0] col;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit model_rm = 1'b0;

    always #2.5 clk = ~clk;

    boot_remap_decoder u_boot_remap_decoder (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .as_i(as_s), .rw_i(rw),
        .dram_size_i(size), .sel_rom_o(s_rom), .sel_dram_o(s_dram),
        .sel_uart_o(s_uart), .sel_cf_o(s_cf), .sel_remap_o(s_remap),
        .bus_err_o(s_err), .rom_addr_o(rom_a), .dram_row_o(row), .dram_col_o(col)
    );

    // expected {err,remap,cf,uart,dram,rom}
    function automatic logic [5:0] exp_sel(logic [31:0] a, logic strobe, logic rm);
        if (!strobe)                                   return 6'b000000;
        if (a >= 32'hFFFF_F000)                        return 6'b000100;
        if (a >= 32'hFFFF_E000 && a <= 32'hFFFF_EFFF)  return 6'b001000;
        if (a >= 32'hFFFF_8000 && a <= 32'hFFFF_8FFF)  return 6'b010000;
        if (!rm && a <= 32'hFEFF_FFFF)                 return 6'b000001;
        if (rm && a <= 32'h07FF_FFFF)                  return 6'b000010;
        if (rm && a >= 32'hFE00_0000 && a <= 32'hFEFF_FFFF) return 6'b000001;
        return 6'b100000;
    endfunction

    task automatic note(string req, bit ok, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] a, logic strobe, logic dir);
        @(negedge clk);
        addr = a; as_s = strobe; rw = dir;
        #1;
    endtask

    // drive one access, check selects and ROM offset, advance the model
    task automatic access(string req, logic [31:0] a, logic strobe, logic dir);
        logic [5:0] e, got;
        drive(a, strobe, dir);
        e   = exp_sel(a, strobe, model_rm);
        got = {s_err, s_remap, s_cf, s_uart, s_dram, s_rom};
        note(req, got == e, {26'b0, got}, {26'b0, e});
        if (e[0]) note(req, rom_a == a[18:0], {13'b0, rom_a}, {13'b0, a[18:0]});
        if (strobe && rst_n && a == 32'hFFFF_8000) model_rm = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; as_s = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_rm = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        addr = 32'h0; as_s = 1'b1; #1;
        note("R1", s_rom && !s_dram, {31'b0, s_rom}, 32'h1);
        do_reset();
        access("R1", 32'h0000_0000, 1'b1, 1'b1);
        access("R9", 32'h0000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_boot_map();
        access("R2", 32'h0012_3456, 1'b1, 1'b1);
        access("R2", 32'h0007_FFFF, 1'b1, 1'b1);
        access("R2", 32'h0008_0000, 1'b1, 1'b0);
        access("R2", 32'h4000_0000, 1'b1, 1'b1);
        access("R2", 32'hFEFF_FFFF, 1'b1, 1'b1);
    endtask

    task automatic t_io_and_holes();
        access("R3", 32'hFFFF_F000, 1'b1, 1'b1);
        access("R3", 32'hFFFF_FFFF, 1'b1, 1'b0);
        access("R3", 32'hFFFF_E000, 1'b1, 1'b1);
        access("R3", 32'hFFFF_EFFF, 1'b1, 1'b1);
        access("R3", 32'hFFFF_8FFF, 1'b1, 1'b1);
        access("R5", 32'hFFFF_8004, 1'b1, 1'b0);
        access("R5", 32'h0000_0100, 1'b1, 1'b1);
        access("R8", 32'hFF00_0000, 1'b1, 1'b1);
        access("R8", 32'hFFFF_7FFF, 1'b1, 1'b1);
        access("R8", 32'hFFFF_9000, 1'b1, 1'b1);
        access("R8", 32'hFFFF_DFFF, 1'b1, 1'b1);
    endtask

    task automatic t_idle();
        access("R9", 32'hFFFF_8000, 1'b0, 1'b0);
        access("R9", 32'hFFFF_F000, 1'b0, 1'b1);
        access("R9", 32'h0000_0000, 1'b1, 1'b1);
    endtask

    task automatic t_trigger(logic dir);
        access("R4", 32'hFFFF_8000, 1'b1, dir);
        access("R4", 32'h0000_0000, 1'b1, 1'b1);
        note("R4", s_dram, {31'b0, s_dram}, 32'h1);
    endtask

    task automatic t_sticky();
        access("R6", 32'hFFFF_8000, 1'b1, 1'b1);
        access("R6", 32'hFFFF_8010, 1'b1, 1'b0);
        access("R6", 32'h0000_0040, 1'b0, 1'b1);
        access("R6", 32'h0000_0040, 1'b1, 1'b1);
    endtask

    task automatic t_post_map();
        access("R7", 32'h07FF_FFFF, 1'b1, 1'b1);
        access("R7", 32'hFE00_0000, 1'b1, 1'b1);
        access("R7", 32'hFE08_1234, 1'b1, 1'b1);
        access("R7", 32'hFEFF_FFFF, 1'b1, 1'b0);
        access("R8", 32'h0800_0000, 1'b1, 1'b1);
        access("R8", 32'hFDFF_FFFF, 1'b1, 1'b1);
        access("R8", 32'hFF00_0000, 1'b1, 1'b1);
        access("R8", 32'hFFFF_0000, 1'b1, 1'b1);
        access("R3", 32'hFFFF_F00E, 1'b1, 1'b1);
        access("R3", 32'hFFFF_E007, 1'b1, 1'b0);
    endtask

    task automatic t_alias();
        logic [31:0] pats [3] = '{32'h05AB_CDEC, 32'h0100_0004, 32'h07FF_FFFF};
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 3; p++) begin
                logic [26:0] m;
                int kw;
                @(negedge clk);
                size = s[1:0];
                kw = (s == 1) ? 26 : (s == 2) ? 27 : 24;
                m = pats[p][26:0] & ((27'd1 << kw) - 27'd1);
                access("R10", pats[p], 1'b1, 1'b1);
                note("R10", col == m[13:2], {20'b0, col}, {20'b0, m[13:2]});
                note("R10", row == m[26:14], {19'b0, row}, {19'b0, m[26:14]});
            end
        end
        size = 2'b10;
    endtask

    task automatic t_reset_clears();
        do_reset();
        access("R6", 32'h0000_0000, 1'b1, 1'b1);
        note("R6", s_rom, {31'b0, s_rom}, 32'h1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_boot_map();
        t_io_and_holes();
        t_idle();
        t_trigger(1'b0);
        t_sticky();
        t_post_map();
        t_alias();
        t_reset_clears();
        t_trigger(1'b1);
        t_reset_clears();
        done = 1'b1;
        repeat (2) @(negedge clk);
        summary();
    end
endmodule